// File: doc/BRIEF.md
# Multi-function pin port

This block owns eight bidirectional pins and lets each one work on its own as a plain input, a plain output, or an alternate-function pin handed to one of three serial engines (SPI, I2C or UART) that sit outside the block. The pins are presented as split input, output and output-enable vectors; the pad tri-state and any level shifting are outside.

Software sets everything through a small register bus: a per-pin mode field, a per-pin function selector, an output data register, and a read-only view of the synchronized pin levels. Each serial engine connects through per-pin vectors: its output, its output enable (SPI and UART), and its input. The block steers a pin to an engine only while that pin is in alternate mode with that engine selected. Every engine input that is not routed is held at the level the engine sees as idle.

Top module: `mfio_port`

## Requirements
- R1: After reset every mode and function field, the output data register and the synchronizer are zero, so every pin is an input with `pin_oe` low and `pin_out` low.
- R2: Register map on `bus_addr`: 0 = mode (pin i at bits 2i+1:2i; 00 input, 01 output, 10 alternate, 11 reserved), 1 = function select (pin i at bits 2i+1:2i; 00 SPI, 01 I2C, 10 UART, 11 reserved), 2 = output data (bits 7:0), 3 = synchronized pin levels (bits 7:0). A write happens on the clock edge where `bus_we` is high. `bus_rdata` is combinational and shows the addressed register, zero-extended. A write to address 3 has no effect.
- R3: A pin in output mode drives `pin_oe` high, and `pin_out` follows its bit of the output data register.
- R4: A pin in input mode keeps `pin_oe` and `pin_out` low. A level on `pin_in` shows in register 3 after exactly two rising clock edges, and not after one.
- R5: A pin in alternate mode with SPI or UART selected copies that engine's `*_out` and `*_oe` bits for the pin onto `pin_out` and `pin_oe`.
- R6: A pin in alternate mode with I2C selected is open drain: `pin_out` is 0, and `pin_oe` is high exactly when `i2c_out` for that pin is 0.
- R7: An engine input bit gets the synchronized pin level while its pin is routed to that engine. Otherwise it is held idle: 0 for `spi_in`, 1 for `i2c_in` and `uart_in`.
- R8: Reserved codes: mode 11 acts as input mode. Function 11 in alternate mode releases the pin (`pin_oe` and `pin_out` low), and all three engine inputs for that pin stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Addressed register contents |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| spi_out | input | 8 | SPI engine output, per pin |
| spi_oe | input | 8 | SPI engine output enable, per pin |
| spi_in | output | 8 | SPI engine input, per pin |
| i2c_out | input | 8 | I2C engine output, per pin (1 releases the line) |
| i2c_in | output | 8 | I2C engine input, per pin |
| uart_out | input | 8 | UART engine output, per pin |
| uart_oe | input | 8 | UART engine output enable, per pin |
| uart_in | output | 8 | UART engine input, per pin |

## Verification
The pad side is combinational from the stored fields. A corrupted mode or function field therefore shows on `pin_oe`, `pin_out` or an engine input in the same cycle the field changes, and a readback of registers 0 to 2 shows it directly. A synchronizer stage that is missing or doubled appears as register 3 or an engine input changing one edge early or late. The bench checks this by sampling after the first edge and again after the second. An open-drain polarity error appears as `pin_oe` taking the same value as `i2c_out` instead of the inverse, or as a non-zero `pin_out` on an I2C pin.

// File: rtl/mfio_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the multi-function pin port.
// Assumes two-bit mode and function fields per pin.
package mfio_pkg;
    typedef enum logic [1:0] {
        PM_IN  = 2'b00,
        PM_OUT = 2'b01,
        PM_ALT = 2'b10,
        PM_RSV = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        AF_SPI  = 2'b00,
        AF_I2C  = 2'b01,
        AF_UART = 2'b10,
        AF_RSV  = 2'b11
    } alt_fn_e;

    localparam logic [1:0] RA_MODE = 2'd0;
    localparam logic [1:0] RA_FSEL = 2'd1;
    localparam logic [1:0] RA_DOUT = 2'd2;
    localparam logic [1:0] RA_DIN  = 2'd3;

    // Levels seen by an engine whose input no pin feeds
    localparam logic IDLE_SPI  = 1'b0;
    localparam logic IDLE_I2C  = 1'b1;
    localparam logic IDLE_UART = 1'b1;
endpackage

// File: rtl/mfio_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no bus coherency is implied.
module mfio_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift pad levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mfio_regs.sv
`timescale 1ns/1ps
// Register file: per-pin mode and function fields, output data,
// and a read-only view of synchronized pin levels.
// Assumes a bus as wide as the packed two-bit-per-pin fields.
module mfio_regs
    import mfio_pkg::*;
#(
    parameter int unsigned NPINS = 8,
    localparam int unsigned FW   = 2 * NPINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [FW-1:0]    bus_wdata,
    output logic [FW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] din,
    output logic [FW-1:0]    mode_o,
    output logic [FW-1:0]    fsel_o,
    output logic [NPINS-1:0] dout_o
);
    logic [FW-1:0]    mode_r;
    logic [FW-1:0]    fsel_r;
    logic [NPINS-1:0] dout_r;

    // Update writable registers; the input view has no storage here
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= '0;
            fsel_r <= '0;
            dout_r <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                RA_MODE: mode_r <= bus_wdata;
                RA_FSEL: fsel_r <= bus_wdata;
                RA_DOUT: dout_r <= bus_wdata[NPINS-1:0];
                default: ;
            endcase
        end
    end

    // Select the addressed register for readback
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_MODE: bus_rdata = mode_r;
            RA_FSEL: bus_rdata = fsel_r;
            RA_DOUT: bus_rdata[NPINS-1:0] = dout_r;
            default: bus_rdata[NPINS-1:0] = din;
        endcase
    end

    assign mode_o = mode_r;
    assign fsel_o = fsel_r;
    assign dout_o = dout_r;
endmodule

// File: rtl/mfio_pinmux.sv
`timescale 1ns/1ps
// Single-pin steering between GPIO and the three serial engines.
// Assumes the input level is already synchronized.
module mfio_pinmux
    import mfio_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [1:0] fsel,
    input  logic       gpio_dout,
    input  logic       sync_in,
    input  logic       spi_o,
    input  logic       spi_oe,
    input  logic       i2c_o,
    input  logic       uart_o,
    input  logic       uart_oe,
    output logic       pin_o,
    output logic       pin_oe,
    output logic       spi_i,
    output logic       i2c_i,
    output logic       uart_i
);
    pin_mode_e m;
    alt_fn_e   f;
    assign m = pin_mode_e'(mode);
    assign f = alt_fn_e'(fsel);

    // Pick pad driver and enable from GPIO or the chosen engine
    always_comb begin
        pin_o  = 1'b0;
        pin_oe = 1'b0;
        if (m == PM_OUT) begin
            pin_o  = gpio_dout;
            pin_oe = 1'b1;
        end else if (m == PM_ALT) begin
            case (f)
                AF_SPI:  begin pin_o = spi_o;  pin_oe = spi_oe;  end
                AF_I2C:  begin pin_o = 1'b0;   pin_oe = ~i2c_o;  end
                AF_UART: begin pin_o = uart_o; pin_oe = uart_oe; end
                default: ;
            endcase
        end
    end

    // Feed each engine the pin level, or its idle level when not routed
    always_comb begin
        spi_i  = IDLE_SPI;
        i2c_i  = IDLE_I2C;
        uart_i = IDLE_UART;
        if (m == PM_ALT) begin
            case (f)
                AF_SPI:  spi_i  = sync_in;
                AF_I2C:  i2c_i  = sync_in;
                AF_UART: uart_i = sync_in;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mfio_port.sv
`timescale 1ns/1ps
// Multi-function pin port: NPINS pads, each independently an input,
// an output, or an alternate-function pin for SPI, I2C or UART.
// Assumes pad tri-state and level shifting are outside the block.
module mfio_port
    import mfio_pkg::*;
#(
    parameter int unsigned NPINS     = 8,
    parameter int unsigned SYNC_DPTH = 2,
    localparam int unsigned FW       = 2 * NPINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [FW-1:0]    bus_wdata,
    output logic [FW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    input  logic [NPINS-1:0] spi_out,
    input  logic [NPINS-1:0] spi_oe,
    output logic [NPINS-1:0] spi_in,
    input  logic [NPINS-1:0] i2c_out,
    output logic [NPINS-1:0] i2c_in,
    input  logic [NPINS-1:0] uart_out,
    input  logic [NPINS-1:0] uart_oe,
    output logic [NPINS-1:0] uart_in
);
    logic [FW-1:0]    mode_q;
    logic [FW-1:0]    fsel_q;
    logic [NPINS-1:0] dout_q;
    logic [NPINS-1:0] sync_q;

    mfio_sync #(.W(NPINS), .STAGES(SYNC_DPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
    );

    mfio_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .din(sync_q),
        .mode_o(mode_q), .fsel_o(fsel_q), .dout_o(dout_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        mfio_pinmux u_mux (
            .mode(mode_q[2*i +: 2]),
            .fsel(fsel_q[2*i +: 2]),
            .gpio_dout(dout_q[i]),
            .sync_in(sync_q[i]),
            .spi_o(spi_out[i]),
            .spi_oe(spi_oe[i]),
            .i2c_o(i2c_out[i]),
            .uart_o(uart_out[i]),
            .uart_oe(uart_oe[i]),
            .pin_o(pin_out[i]),
            .pin_oe(pin_oe[i]),
            .spi_i(spi_in[i]),
            .i2c_i(i2c_in[i]),
            .uart_i(uart_in[i])
        );
    end
endmodule

// File: rtl/mfio_port_chk.sv
`timescale 1ns/1ps
// Property checker for mfio_port, attached by bind.
// Assumes the field encodings from mfio_pkg.
module mfio_port_chk
    import mfio_pkg::*;
#(
    parameter int unsigned NPINS = 8,
    localparam int unsigned FW   = 2 * NPINS
) (
    input logic             clk,
    input logic             rst_n,
    input logic [FW-1:0]    mode_q,
    input logic [FW-1:0]    fsel_q,
    input logic [NPINS-1:0] dout_q,
    input logic [NPINS-1:0] sync_q,
    input logic [NPINS-1:0] pin_in,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] spi_out,
    input logic [NPINS-1:0] spi_oe,
    input logic [NPINS-1:0] spi_in,
    input logic [NPINS-1:0] i2c_out,
    input logic [NPINS-1:0] i2c_in,
    input logic [NPINS-1:0] uart_in
);
    logic [1:0] cyc;

    // Count edges since reset, saturating at two
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc <= 2'd0;
        else if (cyc != 2'd2) cyc <= cyc + 2'd1;
    end

    assert_reset_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd0) |-> (pin_oe == '0));

    assert_sync_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2) |-> (sync_q == $past(pin_in, 2)));

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        assert_gpio_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == PM_OUT) |-> (pin_oe[i] && pin_out[i] == dout_q[i]));

        assert_input_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == PM_IN) |-> (!pin_oe[i] && !pin_out[i]));

        assert_spi_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == PM_ALT && fsel_q[2*i +: 2] == AF_SPI)
            |-> (pin_out[i] == spi_out[i] && pin_oe[i] == spi_oe[i]
                 && spi_in[i] == sync_q[i]));

        assert_i2c_od_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == PM_ALT && fsel_q[2*i +: 2] == AF_I2C)
            |-> (!pin_out[i] && pin_oe[i] == !i2c_out[i]));

        assert_idle_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] != PM_ALT)
            |-> (!spi_in[i] && i2c_in[i] && uart_in[i]));

        assert_rsv_fn_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*i +: 2] == PM_ALT && fsel_q[2*i +: 2] == AF_RSV)
            |-> (!pin_oe[i] && !spi_in[i] && i2c_in[i] && uart_in[i]));
    end
endmodule

bind mfio_port mfio_port_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .mode_q(mode_q), .fsel_q(fsel_q), .dout_q(dout_q), .sync_q(sync_q),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .spi_out(spi_out), .spi_oe(spi_oe), .spi_in(spi_in),
    .i2c_out(i2c_out), .i2c_in(i2c_in), .uart_in(uart_in)
);

// File: tb/tb_mfio_port.sv
`timescale 1ns/1ps
// Self-checking bench for mfio_port: vector table then directed cases.
module tb_mfio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic [7:0]  spi_out = 8'hA5, spi_oe = 8'h0F;
    logic [7:0]  i2c_out = 8'h55;
    logic [7:0]  uart_out = 8'h3C, uart_oe = 8'hF0;
    logic [7:0]  spi_in, i2c_in, uart_in;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mfio_port dut (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .spi_out(spi_out), .spi_oe(spi_oe), .spi_in(spi_in),
        .i2c_out(i2c_out), .i2c_in(i2c_in),
        .uart_out(uart_out), .uart_oe(uart_oe), .uart_in(uart_in)
    );

    // mode, fsel, output data, expected pin_oe, expected pin_out
    localparam logic [55:0] VECS [7] = '{
        {16'h5555, 16'h0000, 8'hC3, 8'hFF, 8'hC3},  // R3 all outputs
        {16'h0000, 16'h0000, 8'hFF, 8'h00, 8'h00},  // R4 all inputs
        {16'hAAAA, 16'h0000, 8'h00, 8'h0F, 8'hA5},  // R5 all SPI
        {16'hAAAA, 16'hAAAA, 8'h00, 8'hF0, 8'h3C},  // R5 all UART
        {16'hAAAA, 16'h5555, 8'h00, 8'hAA, 8'h00},  // R6 all I2C
        {16'hAAAA, 16'hFFFF, 8'h00, 8'h00, 8'h00},  // R8 reserved function
        {16'h9EA4, 16'hC240, 8'h42, 8'h5E, 8'h56}   // R3 R5 R6 R8 mixed
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired R1 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] r;
        repeat (3) @(negedge clk);
        // R1: reset state, before reset is released
        rd(2'd0, r); check("R1 mode reset", r, 16'h0000);
        rd(2'd1, r); check("R1 fsel reset", r, 16'h0000);
        rd(2'd2, r); check("R1 dout reset", r, 16'h0000);
        check("R1 pin_oe reset", {8'h00, pin_oe}, 16'h0000);
        check("R1 pin_out reset", {8'h00, pin_out}, 16'h0000);
        check("R7 idle spi_in", {8'h00, spi_in}, 16'h0000);
        check("R7 idle i2c_in", {8'h00, i2c_in}, 16'h00FF);
        check("R7 idle uart_in", {8'h00, uart_in}, 16'h00FF);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R2 readback plus pad outputs
        for (int v = 0; v < 7; v++) begin
            wr(2'd0, VECS[v][55:40]);
            wr(2'd1, VECS[v][39:24]);
            wr(2'd2, {8'h00, VECS[v][23:16]});
            rd(2'd0, r); check("R2 mode readback", r, VECS[v][55:40]);
            rd(2'd1, r); check("R2 fsel readback", r, VECS[v][39:24]);
            rd(2'd2, r); check("R2 dout readback", r, {8'h00, VECS[v][23:16]});
            check("R3/R5/R6/R8 pin_oe", {8'h00, pin_oe}, {8'h00, VECS[v][15:8]});
            check("R3/R5/R6/R8 pin_out", {8'h00, pin_out}, {8'h00, VECS[v][7:0]});
        end

        // R6: open drain follows a change of the engine output
        wr(2'd0, 16'hAAAA); wr(2'd1, 16'h5555);
        i2c_out = 8'h0F; #1;
        check("R6 i2c oe inverse", {8'h00, pin_oe}, 16'h00F0);
        check("R6 i2c out low", {8'h00, pin_out}, 16'h0000);
        i2c_out = 8'h55;

        // R4: two-edge synchronizer latency in input mode
        wr(2'd0, 16'h0000);
        repeat (3) @(negedge clk);
        pin_in = 8'h96;
        @(posedge clk); #1;
        rd(2'd3, r); check("R4 not after one edge", r, 16'h0000);
        @(posedge clk); #1;
        rd(2'd3, r); check("R4 after two edges", r, 16'h0096);

        // R2: write to the input view is ignored
        wr(2'd3, 16'h0069);
        rd(2'd3, r); check("R2 din write ignored", r, 16'h0096);
        rd(2'd0, r); check("R2 mode kept", r, 16'h0000);

        // R7/R8: routing of engine inputs with the mixed configuration
        wr(2'd0, 16'h9EA4); wr(2'd1, 16'hC240);
        pin_in = 8'hFF;
        repeat (3) @(negedge clk);
        check("R7 spi_in routed", {8'h00, spi_in}, 16'h0004);
        check("R7 i2c_in high", {8'h00, i2c_in}, 16'h00FF);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        check("R7 spi_in low", {8'h00, spi_in}, 16'h0000);
        check("R7 i2c_in routed", {8'h00, i2c_in}, 16'h00F7);
        check("R7 R8 uart_in routed", {8'h00, uart_in}, 16'h00EF);

        // R8: reserved mode acts as input even with output data set
        wr(2'd0, 16'hFFFF); wr(2'd2, 16'h00FF);
        check("R8 reserved mode oe", {8'h00, pin_oe}, 16'h0000);
        check("R8 reserved mode out", {8'h00, pin_out}, 16'h0000);

        // R1: reset returns pins to inputs
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 oe after reset", {8'h00, pin_oe}, 16'h0000);
        rd(2'd2, r); check("R1 dout after reset", r, 16'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule